// File: doc/BRIEF.md
# Quadrature Position Counter with Index Reset

This block turns two quadrature phase signals and an index marker from an incremental encoder into a position count, a direction bit and first-index status. Every legal phase step moves the count by one, which gives four counts per encoder line. The count runs from zero to a programmable ceiling and wraps at both ends. When both phases toggle in the same cycle, the block raises a sticky phase-error flag instead of counting.

When the index marker is high, the first legal phase step after reset or a clear is taken as the first index event. At that step the block latches a first-index flag, stores the direction of motion in a separate bit and remembers the two phase states that bound that step. From then on, a step that crosses that same pair of states while the index is high reloads the count. Moving forward, the count reloads to zero; moving in reverse, it reloads to the ceiling. The stored pair is a physical place on the encoder, not an ordered transition. A reversal while the index is still high therefore reloads the count on the crossing back, and no stale edge is awaited.

All inputs must already be synchronous to the block clock. A synchronous clear returns the count and all status to their starting values.

Top module: `qpos_counter`

## Requirements
- R1: Phase state {A,B} moving 00→10→11→01→00 is forward: each step adds one to the count and sets the direction output to 1. The opposite order subtracts one and sets it to 0. Count and direction take their new value on the clock edge that samples the changed input.
- R2: If A and B both change in the same cycle, the count and direction are unchanged and the phase-error flag sets. The flag stays set until a clear.
- R3: When a forward step finds the count at or above the ceiling, the count becomes 0. A reverse step from 0 gives the ceiling.
- R4: The first legal step with the index high after reset or clear sets the first-index flag. It stores that step's direction (1 forward, 0 reverse) in the first-index direction bit, records the two phase states of the step, and reloads the count.
- R5: An index reload during a forward step sets the count to 0.
- R6: An index reload during a reverse step sets the count to the ceiling.
- R7: Once the first-index flag is set, a step reloads only if the index is high and the step crosses the recorded state pair in either order. All other steps count normally, and the flag stays set.
- R8: If the direction reverses while the index is high, crossing the recorded pair in the new direction reloads at once, with no drift of the count.
- R9: Clear sets the count to 0 and clears the first-index flag, the first-index direction bit, the recorded pair and the phase-error flag. It overrides any step in the same cycle. The direction output still follows a legal step.
- R10: After reset the count is 0, the direction is 1 and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Quadrature phase A, synchronous |
| phase_b | input | 1 | Quadrature phase B, synchronous |
| index_in | input | 1 | Index marker, synchronous |
| clear | input | 1 | Synchronous clear of count and status |
| max_val | input | CNT_W | Count ceiling |
| pos_cnt | output | CNT_W | Position count |
| dir_fwd | output | 1 | 1 when the last legal step was forward |
| first_idx | output | 1 | Sticky first-index flag |
| first_idx_dir | output | 1 | Direction at the first index event |
| phase_err | output | 1 | Sticky illegal-transition flag |

## Verification
Assertions check the following on every cycle:
- both wrap points;
- the reload values for forward and reverse index events;
- the hold of the count on an illegal transition;
- capture of the first-index direction and the stickiness of the first-index flag;
- the effect of clear.

Two behaviours only the bench scenarios can show. The first is that a reload happens only at the recorded pair of states and at no other step while the index is high. The second is that a reversal during a high index gives no drift of the count. The bench walks encoder motion through these cases and compares every cycle against an independent model.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  typedef logic [1:0] phase_t;

  typedef struct packed {
    logic valid;
    logic fwd;
    logic bad;
  } step_t;
endpackage

// File: rtl/qpos_decoder.sv
module qpos_decoder
  import qpos_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   phase_a,
  input  logic   phase_b,
  output phase_t prev_o,
  output phase_t cur_o,
  output step_t  step_o
);
  phase_t prev_q, prev_d, cur, chg;

  always_comb begin
    cur          = {phase_a, phase_b};
    chg          = cur ^ prev_q;
    step_o.valid = (chg == 2'b01) || (chg == 2'b10);
    step_o.bad   = (chg == 2'b11);
    step_o.fwd   = cur[1] ^ prev_q[0];
    prev_d       = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 2'b00;
    else        prev_q <= prev_d;
  end

  assign prev_o = prev_q;
  assign cur_o  = cur;

  // R2
  bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o.bad |-> !step_o.valid);
endmodule

// File: rtl/qpos_index.sv
module qpos_index
  import qpos_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   index_in,
  input  step_t  step,
  input  phase_t prev,
  input  phase_t cur,
  output logic   idx_rst,
  output logic   first_idx,
  output logic   first_dir
);
  logic   fi_q, fi_d, fd_q, fd_d;
  phase_t e0_q, e0_d, e1_q, e1_d;
  logic   on_pair, first_hit;

  always_comb begin
    on_pair   = ((prev == e0_q) && (cur == e1_q)) ||
                ((prev == e1_q) && (cur == e0_q));
    first_hit = step.valid && index_in && !fi_q;
    idx_rst   = step.valid && index_in && (!fi_q || on_pair);
    fi_d = fi_q;
    fd_d = fd_q;
    e0_d = e0_q;
    e1_d = e1_q;
    if (clear) begin
      fi_d = 1'b0;
      fd_d = 1'b0;
      e0_d = 2'b00;
      e1_d = 2'b00;
    end else if (first_hit) begin
      fi_d = 1'b1;
      fd_d = step.fwd;
      e0_d = prev;
      e1_d = cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fi_q <= 1'b0;
      fd_q <= 1'b0;
      e0_q <= 2'b00;
      e1_q <= 2'b00;
    end else begin
      fi_q <= fi_d;
      fd_q <= fd_d;
      e0_q <= e0_d;
      e1_q <= e1_d;
    end
  end

  assign first_idx = fi_q;
  assign first_dir = fd_q;

  // R4
  first_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && step.valid && index_in && !first_idx) |=>
      (first_idx && first_dir == $past(step.fwd)));
  // R7
  first_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_idx && !clear) |=> first_idx);
endmodule

// File: rtl/qpos_count.sv
module qpos_count
  import qpos_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  step_t            step,
  input  logic             idx_rst,
  input  logic [CNT_W-1:0] max_val,
  output logic [CNT_W-1:0] cnt,
  output logic             dir,
  output logic             err
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d, err_q, err_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = step.valid ? step.fwd : dir_q;
    err_d = err_q | step.bad;
    if (clear) begin
      cnt_d = '0;
      err_d = 1'b0;
    end else if (step.valid) begin
      if (idx_rst)       cnt_d = step.fwd ? '0 : max_val;
      else if (step.fwd) cnt_d = (cnt_q >= max_val) ? '0 : cnt_q + ONE;
      else               cnt_d = (cnt_q == '0) ? max_val : cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      err_q <= err_d;
    end
  end

  assign cnt = cnt_q;
  assign dir = dir_q;
  assign err = err_q;

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && step.valid && step.fwd && !idx_rst && cnt >= max_val) |=> cnt == '0);
  // R3
  dn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && step.valid && !step.fwd && !idx_rst && cnt == '0) |=> cnt == $past(max_val));
  // R5
  idx_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && idx_rst && step.valid && step.fwd) |=> cnt == '0);
  // R6
  idx_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && idx_rst && step.valid && !step.fwd) |=> cnt == $past(max_val));
  // R2
  bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && step.bad) |=> ($stable(cnt) && $stable(dir) && err));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0 && !err));
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  input  logic             clear,
  input  logic [CNT_W-1:0] max_val,
  output logic [CNT_W-1:0] pos_cnt,
  output logic             dir_fwd,
  output logic             first_idx,
  output logic             first_idx_dir,
  output logic             phase_err
);
  phase_t prev, cur;
  step_t  step;
  logic   idx_rst;

  qpos_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .prev_o(prev), .cur_o(cur), .step_o(step)
  );

  qpos_index u_idx (
    .clk(clk), .rst_n(rst_n), .clear(clear), .index_in(index_in),
    .step(step), .prev(prev), .cur(cur), .idx_rst(idx_rst),
    .first_idx(first_idx), .first_dir(first_idx_dir)
  );

  qpos_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
    .idx_rst(idx_rst), .max_val(max_val),
    .cnt(pos_cnt), .dir(dir_fwd), .err(phase_err)
  );

  // R9
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!first_idx && !first_idx_dir));
endmodule

// File: tb/sim_qpos_counter.sv
`timescale 1ns/1ps
module sim_qpos_counter;
  localparam int W = 8;
  localparam logic [W-1:0] MAXV = 8'd11;
  localparam int NV = 40;
  // each entry: {phase_a, phase_b, index_in, clear}
  localparam logic [3:0] VEC [NV] = '{
    4'b1000, 4'b1100, 4'b0100, 4'b0000, 4'b1000, 4'b1100, 4'b0100, 4'b0000,
    4'b1000, 4'b1100, 4'b0100, 4'b0000,
    4'b1010, 4'b1110, 4'b0100, 4'b0000, 4'b1010,
    4'b0010, 4'b1010, 4'b1110, 4'b1010, 4'b0010, 4'b0100,
    4'b1000, 4'b0000,
    4'b0001, 4'b0100, 4'b1110, 4'b1000, 4'b0000,
    4'b0010, 4'b1010, 4'b0010, 4'b0100,
    4'b1101, 4'b1100, 4'b1110, 4'b0110, 4'b0100, 4'b1100
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0, idx = 1'b0, clr = 1'b0;
  logic [W-1:0] maxv = MAXV;
  logic [W-1:0] cnt;
  logic dir, fi, fid, err;

  int checks = 0, fails = 0;

  logic [1:0] m_prev, m_e0, m_e1;
  logic [W-1:0] m_cnt;
  logic m_dir, m_fi, m_fid, m_err;
  string why;

  always #2.5 clk = ~clk;

  qpos_counter #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb), .index_in(idx),
    .clear(clr), .max_val(maxv), .pos_cnt(cnt), .dir_fwd(dir),
    .first_idx(fi), .first_idx_dir(fid), .phase_err(err)
  );

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_prev = 2'b00; m_e0 = 2'b00; m_e1 = 2'b00; m_cnt = '0;
    m_dir = 1'b1; m_fi = 1'b0; m_fid = 1'b0; m_err = 1'b0;
  endtask

  task automatic model_step(logic a, logic b, logic ix, logic cl);
    logic [1:0] cur, chg;
    logic valid, fw, hit, pair;
    cur = {a, b};
    chg = cur ^ m_prev;
    valid = (chg == 2'b01) || (chg == 2'b10);
    fw = a ^ m_prev[0];
    pair = (m_prev == m_e0 && cur == m_e1) || (m_prev == m_e1 && cur == m_e0);
    hit = valid && ix && (!m_fi || pair);
    why = "R1";
    if (cl) begin
      why = "R9";
      m_cnt = '0; m_fi = 1'b0; m_fid = 1'b0; m_err = 1'b0;
      m_e0 = 2'b00; m_e1 = 2'b00;
    end else if (chg == 2'b11) begin
      why = "R2";
      m_err = 1'b1;
    end else if (valid) begin
      if (hit) begin
        if (!m_fi) why = "R4";
        else if (fw != m_dir) why = "R8";
        else why = fw ? "R5" : "R6";
        m_cnt = fw ? '0 : maxv;
      end else begin
        if (ix && m_fi) why = "R7";
        if (fw) begin
          if (m_cnt >= maxv) begin m_cnt = '0; why = "R3"; end
          else m_cnt = m_cnt + 1'b1;
        end else begin
          if (m_cnt == '0) begin m_cnt = maxv; why = "R3"; end
          else m_cnt = m_cnt - 1'b1;
        end
      end
      if (!m_fi && ix) begin
        m_fi = 1'b1; m_fid = fw; m_e0 = m_prev; m_e1 = cur;
      end
    end
    if (valid) m_dir = fw;
    m_prev = cur;
  endtask

  task automatic apply(logic [3:0] v);
    @(negedge clk);
    {pa, pb, idx, clr} = v;
    model_step(v[3], v[2], v[1], v[0]);
    @(posedge clk);
    #2;
    check(why, "count", int'(cnt), int'(m_cnt));
    check(why, "dir", int'(dir), int'(m_dir));
    check(why, "first_idx", int'(fi), int'(m_fi));
    check(why, "first_dir", int'(fid), int'(m_fid));
    check(why, "phase_err", int'(err), int'(m_err));
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10", "count", int'(cnt), 0);
    check("R10", "dir", int'(dir), 1);
    check("R10", "first_idx", int'(fi), 0);
    check("R10", "first_dir", int'(fid), 0);
    check("R10", "phase_err", int'(err), 0);

    for (int i = 0; i < NV; i++) apply(VEC[i]);

    // directed: R1 result one edge after the input change
    apply(4'b0000);
    @(negedge clk);
    {pa, pb, idx, clr} = 4'b1000;
    #1;
    check("R1", "count before edge", int'(cnt), int'(m_cnt));
    model_step(1'b1, 1'b0, 1'b0, 1'b0);
    @(posedge clk);
    #2;
    check("R1", "count after edge", int'(cnt), int'(m_cnt));

    // directed: R2 hold of both-phase change, explicit values
    apply(4'b0100);
    check("R2", "hold count", int'(cnt), int'(m_cnt));
    check("R2", "err sticky", int'(err), 1);

    // directed: R10 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    {pa, pb, idx, clr} = 4'b0000;
    #1;
    check("R10", "count in reset", int'(cnt), 0);
    check("R10", "first_idx in reset", int'(fi), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    // R6 reverse first index from zero: explicit max
    apply(4'b0110);
    check("R6", "reverse index reload", int'(cnt), int'(MAXV));
    check("R4", "first dir reverse", int'(fid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule